// File: doc/BRIEF.md
# Access Violation Status and Mask Bank

This block keeps a record of bus access-permission violations for a configurable number of protected slave modules and turns that record into one interrupt line. Each module index owns a sticky status bit and a mask bit. Both kinds of bit are packed thirty-two to a 32-bit word. Mask words sit at the bottom of a small register window and status words sit at a fixed offset above them. When the module count is not a multiple of 32, the last word of each kind is only partly populated.

The permission checker reports a violation as a one-cycle pulse that carries a module index. That pulse sets the matching status bit. Software reads the status words, clears the bits it has handled by writing ones to them, and chooses which modules may raise the interrupt through the mask words. A run-control register has separate start and stop bits, and the interrupt is driven only while the unit is running. Status bits are recorded whether or not the unit is running.

Top module: `viol_status_bank`

## Requirements
- R1: After reset every status bit is 0 and every existing mask bit is 1. The run-control register reads 0 and `irq` is low.
- R2: A pulse on `viol_valid` with an index m below NUM_MODS sets bit m%32 of status word m/32. Status word w is read at byte offset 0x400 + 4*w. The bit stays set until software clears it, and it is recorded whether the unit is running or stopped.
- R3: A write to a status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: If a violation for a module and a software clear of that module's status bit fall in the same cycle, the bit ends up set.
- R5: Mask word w is read and written at byte offset 4*w. A mask bit of 1 keeps that module out of the interrupt, and a mask bit of 0 lets it in.
- R6: `irq` is high exactly when the unit is running and at least one module has both its status bit at 1 and its mask bit at 0. It follows the register state in the same cycle.
- R7: A write to offset 0xF00 with bit 31 set starts the unit, and a write there with bit 2 set stops it. When both bits are set, stop wins. A read of 0xF00 returns the running state in bit 31 and 0 in every other bit.
- R8: In the last word, bits above index (NUM_MODS-1)%32 read 0 and ignore writes. Words beyond the last valid word read 0.
- R9: A violation pulse whose index is NUM_MODS or higher changes no status bit.
- R10: Read data appears on `reg_rdata`, with `reg_rvalid` high, in the cycle after `reg_rd`. An address that decodes to no register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid when `reg_rvalid` is high |
| reg_rvalid | output | 1 | High in the cycle after a read strobe |
| viol_valid | input | 1 | Violation report pulse |
| viol_idx | input | IDX_W | Module index of the reported violation |
| irq | output | 1 | Violation interrupt |

## Verification
The assertions assume that `reg_rd` and `reg_wr` are never high in the same cycle. They also assume that at most one violation is reported per cycle, which the single index port enforces anyway. The stimulus issues one register operation or one violation per step, except in the one directed test that deliberately lines up a violation with a clear of the same bit. That test is there to exercise the priority stated in R4. Addresses in the stimulus are word aligned, and the out-of-range probes use aligned addresses that decode to nothing, or indices just past the last module.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned WSEL_W   = 8;
   localparam int unsigned STAT_OFF = 'h400;
   localparam int unsigned CTRL_OFF = 'hF00;
   localparam int unsigned RUN_BIT  = 31;
   localparam int unsigned HALT_BIT = 2;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_MASK = 2'd1,
      RGN_STAT = 2'd2,
      RGN_CTRL = 2'd3
   } region_e;

   function automatic int unsigned word_count(input int unsigned mods);
      return (mods + WORD_W - 1) / WORD_W;
   endfunction

   function automatic int unsigned bits_in_word(input int unsigned mods,
                                                input int unsigned w);
      int unsigned rest;
      rest = mods - w * WORD_W;
      return (rest >= WORD_W) ? WORD_W : rest;
   endfunction

   function automatic logic [WORD_W-1:0] fill_mask(input int unsigned n);
      logic [WORD_W-1:0] m;
      m = '0;
      for (int unsigned i = 0; i < WORD_W; i++)
         if (i < n) m[i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/vsb_decode.sv
module vsb_decode
   import vsb_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned NUM_WORDS = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region,
   output logic [WSEL_W-1:0] word_sel
);
   localparam int unsigned HI_W = (ADDR_W > 12) ? ADDR_W - 12 : 1;

   logic           hi_zero;
   logic           aligned;
   logic [11:0]    low;
   logic           in_words;

   generate
      if (ADDR_W > 12) begin : g_hi
         assign hi_zero = (addr[ADDR_W-1:12] == HI_W'(0));
      end else begin : g_nohi
         assign hi_zero = 1'b1;
      end
   endgenerate

   assign low      = addr[11:0];
   assign aligned  = (low[1:0] == 2'b00);
   assign word_sel = low[9:2];
   assign in_words = (32'(word_sel) < NUM_WORDS);

   always_comb begin
      region = RGN_NONE;
      if (hi_zero && aligned) begin
         if (low == 12'(CTRL_OFF))
            region = RGN_CTRL;
         else if (low[11:10] == 2'b00 && in_words)
            region = RGN_MASK;
         else if (low[11:10] == 2'b01 && in_words)
            region = RGN_STAT;
      end
   end
endmodule

// File: rtl/vsb_word.sv
module vsb_word
   import vsb_pkg::*;
#(
   parameter int unsigned VALID_BITS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] set_vec,
   input  logic              stat_we,
   input  logic              mask_we,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] stat_q,
   output logic [WORD_W-1:0] mask_q,
   output logic              pend
);
   localparam logic [WORD_W-1:0] LIVE = fill_mask(VALID_BITS);

   logic [WORD_W-1:0] clr_vec;

   initial begin
      if (VALID_BITS < 1 || VALID_BITS > WORD_W)
         $error("vsb_word: VALID_BITS out of range");
   end

   assign clr_vec = stat_we ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= LIVE;
      end else begin
         stat_q <= ((stat_q & ~clr_vec) | set_vec) & LIVE;
         if (mask_we)
            mask_q <= wdata & LIVE;
      end
   end

   assign pend = |(stat_q & ~mask_q);
endmodule

// File: rtl/vsb_irq_tree.sv
module vsb_irq_tree #(
   parameter int unsigned NUM_WORDS = 2
) (
   input  logic [NUM_WORDS-1:0] word_pend,
   input  logic                 run,
   output logic                 irq
);
   localparam int unsigned LVL = (NUM_WORDS <= 1) ? 1 : $clog2(NUM_WORDS);
   localparam int unsigned PAD = 1 << LVL;

   logic [PAD-1:0] lvl_vec [LVL+1];

   assign lvl_vec[0] = PAD'(word_pend);

   generate
      for (genvar l = 0; l < LVL; l++) begin : g_lvl
         for (genvar n = 0; n < (PAD >> (l + 1)); n++) begin : g_node
            assign lvl_vec[l+1][n] = lvl_vec[l][2*n] | lvl_vec[l][2*n+1];
         end
         assign lvl_vec[l+1][PAD-1:(PAD >> (l + 1))] = '0;
      end
   endgenerate

   assign irq = run & lvl_vec[LVL][0];
endmodule

// File: rtl/viol_status_bank.sv
module viol_status_bank
   import vsb_pkg::*;
#(
   parameter int unsigned NUM_MODS = 45,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned IDX_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              reg_rvalid,
   input  logic              viol_valid,
   input  logic [IDX_W-1:0]  viol_idx,
   output logic              irq
);
   localparam int unsigned NUM_WORDS = word_count(NUM_MODS);

   initial begin
      if (NUM_MODS < 1 || NUM_MODS > 256 * WORD_W)
         $error("viol_status_bank: NUM_MODS must be 1..8192");
      if (ADDR_W < 12)
         $error("viol_status_bank: ADDR_W must be at least 12");
      if ((64'd1 << IDX_W) < 64'(NUM_MODS))
         $error("viol_status_bank: IDX_W too narrow for NUM_MODS");
   end

   region_e             region;
   logic [WSEL_W-1:0]   word_sel;
   logic [WORD_W-1:0]   stat_w [NUM_WORDS];
   logic [WORD_W-1:0]   mask_w [NUM_WORDS];
   logic [NUM_WORDS-1:0] word_pend;
   logic [NUM_MODS-1:0] status_all;
   logic [NUM_MODS-1:0] mask_all;
   logic                run_q;
   logic                viol_hit;
   logic [IDX_W-1:0]    viol_word;
   logic [4:0]          viol_bit;
   logic [31:0]         rd_mux;

   vsb_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_WORDS (NUM_WORDS)
   ) i_decode (
      .addr     (reg_addr),
      .region   (region),
      .word_sel (word_sel)
   );

   assign viol_hit  = viol_valid && (32'(viol_idx) < NUM_MODS);
   assign viol_word = viol_idx >> 5;
   assign viol_bit  = viol_idx[4:0];

   generate
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
         logic [WORD_W-1:0] set_vec;
         logic              stat_we;
         logic              mask_we;

         assign set_vec = (viol_hit && viol_word == IDX_W'(w))
                          ? (WORD_W'(1) << viol_bit) : '0;
         assign stat_we = reg_wr && region == RGN_STAT && word_sel == WSEL_W'(w);
         assign mask_we = reg_wr && region == RGN_MASK && word_sel == WSEL_W'(w);

         vsb_word #(
            .VALID_BITS (bits_in_word(NUM_MODS, w))
         ) i_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_vec (set_vec),
            .stat_we (stat_we),
            .mask_we (mask_we),
            .wdata   (reg_wdata),
            .stat_q  (stat_w[w]),
            .mask_q  (mask_w[w]),
            .pend    (word_pend[w])
         );
      end

      for (genvar m = 0; m < NUM_MODS; m++) begin : g_flat
         assign status_all[m] = stat_w[m / WORD_W][m % WORD_W];
         assign mask_all[m]   = mask_w[m / WORD_W][m % WORD_W];
      end
   endgenerate

   // run control: stop has priority over start
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= 1'b0;
      else if (reg_wr && region == RGN_CTRL) begin
         if (reg_wdata[HALT_BIT])
            run_q <= 1'b0;
         else if (reg_wdata[RUN_BIT])
            run_q <= 1'b1;
      end
   end

   always_comb begin
      rd_mux = '0;
      case (region)
         RGN_CTRL: rd_mux[RUN_BIT] = run_q;
         RGN_MASK: begin
            for (int w = 0; w < NUM_WORDS; w++)
               if (word_sel == WSEL_W'(w)) rd_mux = mask_w[w];
         end
         RGN_STAT: begin
            for (int w = 0; w < NUM_WORDS; w++)
               if (word_sel == WSEL_W'(w)) rd_mux = stat_w[w];
         end
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata  <= '0;
         reg_rvalid <= 1'b0;
      end else begin
         reg_rvalid <= reg_rd;
         if (reg_rd)
            reg_rdata <= rd_mux;
      end
   end

   vsb_irq_tree #(
      .NUM_WORDS (NUM_WORDS)
   ) i_irq (
      .word_pend (word_pend),
      .run       (run_q),
      .irq       (irq)
   );
endmodule

// File: rtl/vsb_checker.sv
module vsb_checker
   import vsb_pkg::*;
#(
   parameter int unsigned NUM_MODS = 45,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned IDX_W    = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_wr,
   input logic                reg_rd,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic [31:0]         reg_wdata,
   input logic [31:0]         reg_rdata,
   input logic                reg_rvalid,
   input logic                viol_valid,
   input logic [IDX_W-1:0]    viol_idx,
   input logic                irq,
   input logic [NUM_MODS-1:0] status_all,
   input logic [NUM_MODS-1:0] mask_all
);
   localparam int unsigned NW = word_count(NUM_MODS);
   localparam logic [31:0] LAST_LIVE = fill_mask(bits_in_word(NUM_MODS, NW - 1));
   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFF);
   localparam logic [ADDR_W-1:0] STAT0_A = ADDR_W'(STAT_OFF);
   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(STAT_OFF + 4 * (NW - 1));

   logic [IDX_W-1:0] idx_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idx_d <= '0;
      else        idx_d <= viol_idx;
   end

   AST_VIOL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_valid && 32'(viol_idx) < NUM_MODS) |=> |(status_all & (NUM_MODS'(1) << idx_d))); // R2

   AST_W1C_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == STAT0_A && reg_wdata[0] && !(viol_valid && viol_idx == '0))
      |=> !status_all[0]); // R3

   AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == STAT0_A && reg_wdata[0] && viol_valid && viol_idx == '0)
      |=> status_all[0]); // R4

   AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> |(status_all & ~mask_all)); // R6

   AST_STOP_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == CTRL_A && reg_wdata[HALT_BIT]) |=> !irq); // R7

   AST_PAD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == LAST_A) |=> ((reg_rdata & ~LAST_LIVE) == '0)); // R8

   AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> reg_rvalid); // R10
endmodule

bind viol_status_bank vsb_checker #(
   .NUM_MODS (NUM_MODS),
   .ADDR_W   (ADDR_W),
   .IDX_W    (IDX_W)
) i_vsb_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_rd     (reg_rd),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .reg_rvalid (reg_rvalid),
   .viol_valid (viol_valid),
   .viol_idx   (viol_idx),
   .irq        (irq),
   .status_all (status_all),
   .mask_all   (mask_all)
);

// File: tb/test_viol_status_bank.sv
module test_viol_status_bank;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_MODS   = 45;
   localparam int ADDR_W     = 12;
   localparam int IDX_W      = 16;

   localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_VIO = 2'd2, OP_IRQ = 2'd3;

   // vector: {op[2], req[4], addr[12], data[32], expected[32]}
   function automatic logic [81:0] vec(input logic [1:0] op, input logic [3:0] rq,
                                       input logic [11:0] a, input logic [31:0] d,
                                       input logic [31:0] e);
      return {op, rq, a, d, e};
   endfunction

   localparam int NV = 32;
   localparam logic [81:0] VEC [NV] = '{
      vec(OP_RD,  4'd1,  12'h000, 32'h0,        32'hFFFF_FFFF), // R1 mask word 0
      vec(OP_RD,  4'd1,  12'h004, 32'h0,        32'h0000_1FFF), // R1 partial mask word
      vec(OP_RD,  4'd1,  12'h400, 32'h0,        32'h0),         // R1 status clear
      vec(OP_RD,  4'd1,  12'hF00, 32'h0,        32'h0),         // R1 stopped
      vec(OP_IRQ, 4'd1,  12'h000, 32'h0,        32'h0),         // R1
      vec(OP_VIO, 4'd2,  12'h000, 32'd5,        32'h0),
      vec(OP_RD,  4'd2,  12'h400, 32'h0,        32'h0000_0020), // R2 recorded while stopped
      vec(OP_IRQ, 4'd6,  12'h000, 32'h0,        32'h0),         // R6 stopped and masked
      vec(OP_WR,  4'd7,  12'hF00, 32'h8000_0000, 32'h0),
      vec(OP_RD,  4'd7,  12'hF00, 32'h0,        32'h8000_0000), // R7 running
      vec(OP_IRQ, 4'd5,  12'h000, 32'h0,        32'h0),         // R5 masked
      vec(OP_WR,  4'd5,  12'h000, 32'hFFFF_FFDF, 32'h0),
      vec(OP_RD,  4'd5,  12'h000, 32'h0,        32'hFFFF_FFDF), // R5 readback
      vec(OP_IRQ, 4'd6,  12'h000, 32'h0,        32'h1),         // R6 unmasked pending
      vec(OP_VIO, 4'd2,  12'h000, 32'd44,       32'h0),
      vec(OP_RD,  4'd2,  12'h404, 32'h0,        32'h0000_1000), // R2 last index
      vec(OP_WR,  4'd3,  12'h400, 32'h0,        32'h0),
      vec(OP_RD,  4'd3,  12'h400, 32'h0,        32'h0000_0020), // R3 zero keeps
      vec(OP_WR,  4'd3,  12'h400, 32'h0000_0020, 32'h0),
      vec(OP_RD,  4'd3,  12'h400, 32'h0,        32'h0),         // R3 one clears
      vec(OP_IRQ, 4'd6,  12'h000, 32'h0,        32'h0),         // R6 only masked pending
      vec(OP_WR,  4'd5,  12'h004, 32'h0,        32'h0),
      vec(OP_IRQ, 4'd6,  12'h000, 32'h0,        32'h1),         // R6 word 1 source
      vec(OP_WR,  4'd7,  12'hF00, 32'h8000_0004, 32'h0),
      vec(OP_IRQ, 4'd7,  12'h000, 32'h0,        32'h0),         // R7 stop wins
      vec(OP_RD,  4'd7,  12'hF00, 32'h0,        32'h0),         // R7
      vec(OP_WR,  4'd8,  12'h404, 32'hFFFF_FFFF, 32'h0),
      vec(OP_VIO, 4'd9,  12'h000, 32'd45,       32'h0),
      vec(OP_RD,  4'd9,  12'h404, 32'h0,        32'h0),         // R9 dropped, R3 cleared
      vec(OP_WR,  4'd8,  12'h004, 32'hFFFF_FFFF, 32'h0),
      vec(OP_RD,  4'd8,  12'h004, 32'h0,        32'h0000_1FFF), // R8 pad ignores write
      vec(OP_RD,  4'd10, 12'h408, 32'h0,        32'h0)          // R10 R8 missing word
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic              reg_rd = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic              reg_rvalid;
   logic              viol_valid = 1'b0;
   logic [IDX_W-1:0]  viol_idx = '0;
   logic              irq;

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   viol_status_bank #(
      .NUM_MODS (NUM_MODS),
      .ADDR_W   (ADDR_W),
      .IDX_W    (IDX_W)
   ) i_viol_status_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .reg_rvalid (reg_rvalid),
      .viol_valid (viol_valid),
      .viol_idx   (viol_idx),
      .irq        (irq)
   );

   task automatic check(input int rq, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d actual=%h expected=%h", rq, act, exp);
      end
   endtask

   // one operation, entered and left at a falling edge
   task automatic step(input logic [81:0] v);
      logic [1:0]  op;
      logic [3:0]  rq;
      logic [11:0] a;
      logic [31:0] d, e;
      {op, rq, a, d, e} = v;
      reg_addr = a;
      reg_wdata = d;
      reg_rd = (op == OP_RD);
      reg_wr = (op == OP_WR);
      viol_valid = (op == OP_VIO);
      viol_idx = d[IDX_W-1:0];
      @(negedge clk);
      reg_rd = 1'b0;
      reg_wr = 1'b0;
      viol_valid = 1'b0;
      if (op == OP_RD) begin
         check(10, {31'b0, reg_rvalid}, 32'h1); // R10 rvalid
         check(int'(rq), reg_rdata, e);
      end else if (op == OP_IRQ)
         check(int'(rq), {31'b0, irq}, e);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NV; i++) step(VEC[i]);

      // R4: clear and new violation on the same bit in one cycle
      step(vec(OP_VIO, 4'd4, 12'h000, 32'd3, 32'h0));
      reg_wr = 1'b1; reg_addr = 12'h400; reg_wdata = 32'h0000_0008;
      viol_valid = 1'b1; viol_idx = 16'd3;
      @(negedge clk);
      reg_wr = 1'b0; viol_valid = 1'b0;
      step(vec(OP_RD, 4'd4, 12'h400, 32'h0, 32'h0000_0008)); // R4 set wins

      // R10: unmapped aligned address reads zero
      step(vec(OP_RD, 4'd10, 12'h800, 32'h0, 32'h0));

      // R1: reset mid-run restores defaults
      step(vec(OP_WR, 4'd1, 12'hF00, 32'h8000_0000, 32'h0));
      step(vec(OP_WR, 4'd1, 12'h000, 32'h0, 32'h0));
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check(1, {31'b0, irq}, 32'h0); // R1 irq low
      step(vec(OP_RD, 4'd1, 12'h000, 32'h0, 32'hFFFF_FFFF)); // R1 mask restored
      step(vec(OP_RD, 4'd1, 12'h400, 32'h0, 32'h0));         // R1 status cleared
      step(vec(OP_RD, 4'd1, 12'hF00, 32'h0, 32'h0));         // R1 stopped

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule